// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the slave-side protocol engine that sits between a four-wire serial bus and the storage of a small byte-addressed serial memory. It runs in SPI mode 0 and moves every field most significant bit first. A transfer starts when the active-low select falls. The engine then collects an 8-bit command. For array commands it also collects a 16-bit address. After that it either streams read bytes out on the serial output with an automatically advancing address, or it hands each complete incoming data byte, together with its target address, to a downstream write engine.

A status/protection unit and a write engine use the pulses that the block produces. There is one pulse per accepted command, one per complete write byte, and one per rising edge of the select. The block also reads array bytes and the status byte through plain combinational inputs. A pause input lets the bus master freeze a transfer in the middle and pick it up again later. A busy input, driven by the write engine, locks out every command except the status read while a self-timed write is running. The memory array and the write-cycle timing live outside this block.

All bus pins are brought into a fast system clock through two-flop synchronizers. Bus edges are found in that clock domain.

Top module: `spimem_front`

## Requirements
- R1: After reset, `so_oe_o` is 0, `op_o` is 0, and `op_stb_o`, `wbyte_stb_o` and `cs_rise_o` are all 0.
- R2: The 8 bits after a select fall form the command. Bits 7..4 must be zero and bit 3 is ignored. Bits 2..0 select the command: 110 set write enable (`op_o`=1), 100 clear write enable (2), 101 read status (3), 001 write status (4), 011 read array (5), 010 write array (6). An accepted command gives one `op_stb_o` pulse, and `op_o` holds the code until the next select fall.
- R3: Any other command byte produces no `op_stb_o`, no `wbyte_stb_o` and no output enable until the next select fall. The next transfer then works normally.
- R4: Read-array and write-array commands are followed by a 16-bit address. Only its low `ADDR_W` bits (11 by default) are used; the upper bits are ignored.
- R5: During a read-array transfer, SI is ignored after the address. Bytes at `rd_addr_o` are shifted out MSB first, and the address advances by one after each byte, wrapping from the top address to 0.
- R6: During a read-status transfer, `status_i` is shifted out MSB first, repeatedly, for as long as the select stays low.
- R7: During a write-array transfer, each complete 8-bit byte gives one `wbyte_stb_o` pulse carrying the byte and its address. The address then advances only in its low `PAGE_W` bits (5 by default), wrapping inside the page. A partial byte at the select rise gives no pulse.
- R8: A write-status command accepts exactly one data byte. That byte gives one `wbyte_stb_o` with `op_o`=4. Any later bits in the same transfer are ignored.
- R9: While `busy_i` is 1 at command completion, every command except read status is dropped: no `op_stb_o` and no `wbyte_stb_o`. Read status still works.
- R10: Pulling the pause input low while SCK is low freezes the transfer. The output enable goes to 0, and SCK edges and SI are ignored. Releasing the pause while SCK is low resumes exactly where the transfer stopped.
- R11: `so_oe_o` is 0 whenever the select is high.
- R12: Every rising edge of the select gives exactly one single-cycle `cs_rise_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the bus master |
| cs_n_i | input | 1 | Active-low select |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Active-low pause |
| busy_i | input | 1 | Self-timed write cycle in progress |
| rd_data_i | input | 8 | Array byte at `rd_addr_o` |
| status_i | input | 8 | Status byte to shift out |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial data out driver |
| rd_addr_o | output | ADDR_W | Current array address |
| op_stb_o | output | 1 | One-cycle pulse on an accepted command |
| op_o | output | 3 | Code of the current command |
| wbyte_stb_o | output | 1 | One-cycle pulse on a complete write byte |
| wbyte_o | output | 8 | Received write byte |
| wbyte_addr_o | output | ADDR_W | Address of the received write byte |
| cs_rise_o | output | 1 | One-cycle pulse on a select rising edge |

## Verification
The assertions assume that the bus pins change slowly compared with the system clock. In particular, an SCK edge never lands in the same synchronized cycle as a select edge, and `busy_i` never changes within a command byte. The bench keeps to this. Every pin change is made on a falling system-clock edge. SCK holds each level for eight system cycles, and the select is moved only while SCK has been low for a full half period. The pause pin is moved only with SCK low, and `busy_i` is changed only between transfers.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WREN  = 3'd1,
    OP_WRDI  = 3'd2,
    OP_RDSR  = 3'd3,
    OP_WRSR  = 3'd4,
    OP_READ  = 3'd5,
    OP_WRITE = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_RDATA,
    ST_SDATA,
    ST_WDATA,
    ST_SWR,
    ST_DROP
  } st_e;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
  parameter int         N       = 4,
  parameter int         STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spimem_link.sv
module spimem_link (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_s,
  input  logic hold_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic held
);
  logic sck_q, cs_q, held_q;
  logic held_d;

  // pause state only changes while the serial clock is low
  always_comb begin
    held_d = held_q;
    if (!sck_s) held_d = ~hold_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      held_q <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      cs_q   <= cs_s;
      held_q <= held_d;
    end
  end

  assign sck_rise = sck_s & ~sck_q & ~held_q & ~cs_s;
  assign sck_fall = ~sck_s & sck_q & ~held_q & ~cs_s;
  assign cs_fall  = ~cs_s & cs_q;
  assign cs_rise  = cs_s & ~cs_q;
  assign held     = held_q;
endmodule

// File: rtl/spimem_opdec.sv
module spimem_opdec
  import spimem_pkg::*;
(
  input  logic [BYTE_W-1:0] code_i,
  output op_e               op_o,
  output logic              valid_o
);
  always_comb begin
    op_o    = OP_NONE;
    valid_o = 1'b0;
    if (code_i[7:4] == 4'b0000) begin
      valid_o = 1'b1;
      unique case (code_i[2:0])
        3'b110:  op_o = OP_WREN;
        3'b100:  op_o = OP_WRDI;
        3'b101:  op_o = OP_RDSR;
        3'b001:  op_o = OP_WRSR;
        3'b011:  op_o = OP_READ;
        3'b010:  op_o = OP_WRITE;
        default: valid_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/spimem_front.sv
module spimem_front
  import spimem_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int AFLD_W  = 16,
  parameter int PAGE_W  = 5,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  input  logic              hold_n_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  input  logic [7:0]        status_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              op_stb_o,
  output logic [2:0]        op_o,
  output logic              wbyte_stb_o,
  output logic [7:0]        wbyte_o,
  output logic [ADDR_W-1:0] wbyte_addr_o,
  output logic              cs_rise_o
);
  localparam int CNT_W = $clog2(AFLD_W);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] AFLD_LAST = CNT_W'(AFLD_W - 1);

  logic [3:0] pins_s;
  logic sck_s, cs_s, si_s, hold_s;
  logic sck_rise, sck_fall, cs_fall, cs_rise, held;

  spimem_sync #(.N(4), .STAGES(SYNC_N), .RST_VAL(4'b1010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({hold_n_i, si_i, cs_n_i, sck_i}),
    .q_o(pins_s)
  );
  assign {hold_s, si_s, cs_s, sck_s} = pins_s;

  spimem_link u_link (
    .clk(clk), .rst_n(rst_n),
    .sck_s(sck_s), .cs_s(cs_s), .hold_s(hold_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .held(held)
  );

  st_e                 st_q, st_d;
  op_e                 op_q, op_d, dec_op;
  logic                dec_ok;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [AFLD_W-2:0]   shin_q, shin_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [7:0]          shout_q, shout_d;
  logic                oe_q, oe_d;
  logic                ostb_q, ostb_d;
  logic                wstb_q, wstb_d;
  logic [7:0]          wb_q, wb_d;
  logic [ADDR_W-1:0]   wba_q, wba_d;
  logic                csr_q;
  logic [AFLD_W-1:0]   word_in;
  logic [7:0]          byte_in;

  assign word_in = {shin_q, si_s};
  assign byte_in = word_in[7:0];

  spimem_opdec u_dec (.code_i(byte_in), .op_o(dec_op), .valid_o(dec_ok));

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    cnt_d   = cnt_q;
    shin_d  = shin_q;
    addr_d  = addr_q;
    shout_d = shout_q;
    oe_d    = oe_q;
    ostb_d  = 1'b0;
    wstb_d  = 1'b0;
    wb_d    = wb_q;
    wba_d   = wba_q;
    if (cs_fall) begin
      st_d  = ST_OPC;
      op_d  = OP_NONE;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (cs_s) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_OPC: if (sck_rise) begin
          shin_d = word_in[AFLD_W-2:0];
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == BYTE_LAST) begin
            cnt_d = '0;
            if (!dec_ok || (busy_i && dec_op != OP_RDSR)) begin
              st_d = ST_DROP;
            end else begin
              op_d   = dec_op;
              ostb_d = 1'b1;
              unique case (dec_op)
                OP_RDSR:            st_d = ST_SDATA;
                OP_WRSR:            st_d = ST_SWR;
                OP_READ, OP_WRITE:  st_d = ST_ADDR;
                default:            st_d = ST_DROP;
              endcase
            end
          end
        end
        ST_ADDR: if (sck_rise) begin
          shin_d = word_in[AFLD_W-2:0];
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == AFLD_LAST) begin
            cnt_d  = '0;
            addr_d = word_in[ADDR_W-1:0];
            st_d   = (op_q == OP_READ) ? ST_RDATA : ST_WDATA;
          end
        end
        ST_RDATA, ST_SDATA: begin
          if (sck_fall) begin
            oe_d = 1'b1;
            if (cnt_q == '0) shout_d = (st_q == ST_RDATA) ? rd_data_i : status_i;
            else             shout_d = {shout_q[6:0], 1'b0};
          end else if (sck_rise) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == BYTE_LAST) begin
              cnt_d = '0;
              if (st_q == ST_RDATA) addr_d = addr_q + ADDR_W'(1);
            end
          end
        end
        ST_WDATA, ST_SWR: if (sck_rise) begin
          shin_d = word_in[AFLD_W-2:0];
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == BYTE_LAST) begin
            cnt_d  = '0;
            wstb_d = 1'b1;
            wb_d   = byte_in;
            wba_d  = addr_q;
            if (st_q == ST_WDATA)
              addr_d = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
            else
              st_d = ST_DROP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      cnt_q   <= '0;
      shin_q  <= '0;
      addr_q  <= '0;
      shout_q <= '0;
      oe_q    <= 1'b0;
      ostb_q  <= 1'b0;
      wstb_q  <= 1'b0;
      wb_q    <= '0;
      wba_q   <= '0;
      csr_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      shin_q  <= shin_d;
      addr_q  <= addr_d;
      shout_q <= shout_d;
      oe_q    <= oe_d;
      ostb_q  <= ostb_d;
      wstb_q  <= wstb_d;
      wb_q    <= wb_d;
      wba_q   <= wba_d;
      csr_q   <= cs_rise;
    end
  end

  assign so_o         = shout_q[7];
  assign so_oe_o      = oe_q & ~held & ~cs_s;
  assign rd_addr_o    = addr_q;
  assign op_stb_o     = ostb_q;
  assign op_o         = op_q;
  assign wbyte_stb_o  = wstb_q;
  assign wbyte_o      = wb_q;
  assign wbyte_addr_o = wba_q;
  assign cs_rise_o    = csr_q;
endmodule

// File: rtl/spimem_front_chk.sv
module spimem_front_chk
  import spimem_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       so_oe_o,
  input logic [2:0] op_o,
  input logic       op_stb_o,
  input logic       wbyte_stb_o,
  input logic       cs_rise_o,
  input logic       busy_i,
  input logic       held
);
  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe_o |-> (op_o == OP_READ || op_o == OP_RDSR)); // R5

  AST_WBYTE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    wbyte_stb_o |-> (op_o == OP_WRITE || op_o == OP_WRSR)); // R7

  AST_BUSY_RDSR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_stb_o && busy_i) |-> (op_o == OP_RDSR)); // R9

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (!so_oe_o && !wbyte_stb_o && !op_stb_o)); // R10

  AST_CSRISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_o |=> !cs_rise_o); // R12

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_stb_o, wbyte_stb_o, cs_rise_o})); // R2
endmodule

bind spimem_front spimem_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .so_oe_o(so_oe_o), .op_o(op_o),
  .op_stb_o(op_stb_o), .wbyte_stb_o(wbyte_stb_o), .cs_rise_o(cs_rise_o),
  .busy_i(busy_i), .held(held)
);

// File: tb/spimem_front_tb.sv
module spimem_front_tb;
  localparam int AW   = 11;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] status = 8'hA5;
  logic so_o, so_oe_o, op_stb_o, wbyte_stb_o, cs_rise_o;
  logic [2:0] op_o;
  logic [7:0] wbyte_o;
  logic [AW-1:0] rd_addr_o, wbyte_addr_o;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
    return (a[7:0] * 8'd13) ^ {5'b0, a[10:8]} ^ 8'h27;
  endfunction
  assign rd_data = mem_f(rd_addr_o);

  spimem_front u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
    .hold_n_i(hold_n), .busy_i(busy), .rd_data_i(rd_data), .status_i(status),
    .so_o(so_o), .so_oe_o(so_oe_o), .rd_addr_o(rd_addr_o), .op_stb_o(op_stb_o),
    .op_o(op_o), .wbyte_stb_o(wbyte_stb_o), .wbyte_o(wbyte_o),
    .wbyte_addr_o(wbyte_addr_o), .cs_rise_o(cs_rise_o)
  );

  int n_chk = 0, n_bad = 0;
  int op_cnt = 0, wb_cnt = 0, csr_cnt = 0, csr_dbl = 0, csr_exp = 0;
  logic [2:0] last_op = '0;
  logic [7:0] wb_dat [16];
  logic [AW-1:0] wb_adr [16];
  logic [2:0] wb_op [16];
  logic csr_prev = 1'b0, oe_seen = 1'b0;
  bit done = 0;

  always @(negedge clk) begin
    if (op_stb_o) begin op_cnt++; last_op = op_o; end
    if (wbyte_stb_o && wb_cnt < 16) begin
      wb_dat[wb_cnt] = wbyte_o; wb_adr[wb_cnt] = wbyte_addr_o; wb_op[wb_cnt] = op_o;
      wb_cnt++;
    end
    if (cs_rise_o) csr_cnt++;
    if (cs_rise_o && csr_prev) csr_dbl++;
    csr_prev = cs_rise_o;
    if (so_oe_o) oe_seen = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b, output logic smp);
    si = b;
    wait_clk(HALF);
    smp = so_o;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) pulse(tx[i], rx[i]);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    cs_n = 1'b1;
    csr_exp++;
    wait_clk(12);
  endtask

  task automatic t_reset();
    check(so_oe_o == 0 && op_o == 0 && !op_stb_o && !wbyte_stb_o && !cs_rise_o,
          "R1 reset state", {so_oe_o, op_o, op_stb_o, wbyte_stb_o, cs_rise_o}, 0);
  endtask

  task automatic t_opcodes();
    logic [7:0] codes [6] = '{8'h06, 8'h0C, 8'h05, 8'h09, 8'h0B, 8'h02};
    logic [7:0] rx;
    for (int i = 0; i < 6; i++) begin
      int c0 = op_cnt;
      cs_begin(); xfer(codes[i], rx); cs_end();
      check(op_cnt == c0 + 1 && last_op == 3'(i + 1), "R2 opcode decode",
            {codes[i], 5'b0, last_op}, {codes[i], 5'b0, 3'(i + 1)});
    end
  endtask

  task automatic t_invalid();
    logic [7:0] rx;
    int c0 = op_cnt, w0 = wb_cnt;
    oe_seen = 1'b0;
    cs_begin(); xfer(8'h12, rx); xfer(8'h00, rx); xfer(8'h10, rx); xfer(8'hAA, rx); cs_end();
    cs_begin(); xfer(8'h07, rx); xfer(8'h5A, rx); cs_end();
    check(op_cnt == c0 && wb_cnt == w0, "R3 invalid opcode no strobes", op_cnt - c0 + wb_cnt - w0, 0);
    check(oe_seen == 1'b0, "R3 invalid opcode output stays off", oe_seen, 0);
  endtask

  task automatic t_read(input logic [15:0] a16, input int nb, input string req);
    logic [7:0] rx;
    logic [AW-1:0] a = a16[AW-1:0];
    cs_begin(); xfer(8'h03, rx); xfer(a16[15:8], rx); xfer(a16[7:0], rx);
    for (int k = 0; k < nb; k++) begin
      xfer(8'hFF, rx);
      check(rx == mem_f(a), req, rx, mem_f(a));
      a = a + 1'b1;
    end
    check(so_oe_o == 1'b1, "R5 output enabled while reading", so_oe_o, 1);
    cs_end();
    check(so_oe_o == 1'b0, "R11 output off after select rise", so_oe_o, 0);
  endtask

  task automatic t_rdsr();
    logic [7:0] rx;
    cs_begin(); xfer(8'h05, rx);
    for (int k = 0; k < 2; k++) begin
      xfer(8'h00, rx);
      check(rx == status, "R6 status stream", rx, status);
    end
    cs_end();
  endtask

  task automatic t_write();
    logic [7:0] rx;
    logic [7:0] d [3] = '{8'h11, 8'h22, 8'h33};
    logic [AW-1:0] ea [3] = '{11'h45E, 11'h45F, 11'h440};
    int w0 = wb_cnt;
    cs_begin(); xfer(8'h02, rx); xfer(8'hFC, rx); xfer(8'h5E, rx);
    for (int k = 0; k < 3; k++) xfer(d[k], rx);
    for (int i = 0; i < 4; i++) pulse(1'b1, rx[0]);
    cs_end();
    check(wb_cnt == w0 + 3, "R7 write byte count", wb_cnt - w0, 3);
    for (int k = 0; k < 3; k++)
      check(wb_dat[w0 + k] == d[k] && wb_adr[w0 + k] == ea[k], "R7 write byte and page address",
            {wb_dat[w0 + k], 5'b0, wb_adr[w0 + k]}, {d[k], 5'b0, ea[k]});
  endtask

  task automatic t_wrsr();
    logic [7:0] rx;
    int w0 = wb_cnt;
    cs_begin(); xfer(8'h01, rx); xfer(8'h8C, rx); xfer(8'h77, rx); cs_end();
    check(wb_cnt == w0 + 1, "R8 single status byte", wb_cnt - w0, 1);
    check(wb_dat[w0] == 8'h8C && wb_op[w0] == 3'd4, "R8 status byte value",
          {wb_dat[w0], 5'b0, wb_op[w0]}, {8'h8C, 8'h04});
  endtask

  task automatic t_busy();
    logic [7:0] rx;
    int c0, w0;
    busy = 1'b1;
    c0 = op_cnt; w0 = wb_cnt;
    cs_begin(); xfer(8'h06, rx); cs_end();
    cs_begin(); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h10, rx); xfer(8'h99, rx); cs_end();
    check(op_cnt == c0 && wb_cnt == w0, "R9 busy drops commands", op_cnt - c0 + wb_cnt - w0, 0);
    cs_begin(); xfer(8'h05, rx); xfer(8'h00, rx); cs_end();
    check(op_cnt == c0 + 1 && last_op == 3'd3 && rx == status, "R9 status read while busy",
          {last_op, rx}, {3'd3, status});
    busy = 1'b0;
  endtask

  task automatic t_hold();
    logic [7:0] rx, b;
    cs_begin(); xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h10, rx);
    for (int i = 7; i >= 4; i--) pulse(1'b0, b[i]);
    hold_n = 1'b0;
    wait_clk(HALF);
    for (int j = 0; j < 3; j++) begin
      si = j[0]; sck = 1'b1; wait_clk(HALF);
      check(so_oe_o == 1'b0, "R10 output off while paused", so_oe_o, 0);
      sck = 1'b0; wait_clk(HALF);
    end
    hold_n = 1'b1;
    wait_clk(HALF);
    for (int i = 3; i >= 0; i--) pulse(1'b0, b[i]);
    check(b == mem_f(11'h010), "R10 resume after pause", b, mem_f(11'h010));
    xfer(8'h00, rx);
    check(rx == mem_f(11'h011), "R10 next byte after pause", rx, mem_f(11'h011));
    cs_end();
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_opcodes();
    t_invalid();
    t_read(16'hF803, 3, "R4 R5 read upper address bits ignored");
    t_read(16'h07FE, 4, "R5 read wraps at top");
    t_rdsr();
    t_write();
    t_wrsr();
    t_busy();
    t_hold();
    check(csr_cnt == csr_exp && csr_dbl == 0, "R12 select rise pulses", csr_cnt, csr_exp);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule